// File: doc/BRIEF.md
# HDLC Command Transmitter

This block is a bit-serial transmitter that a processor drives through a small command port and a byte FIFO. Software first loads the bytes of a frame into the FIFO. It then issues a command that starts the frame in one of two modes. In HDLC mode the serializer sends an opening flag, then the bytes with zero insertion, then a 16-bit frame check sequence and a closing flag. In transparent mode it sends the raw bytes with no framing at all.

A separate end-of-message command tells the serializer that the FIFO holds the tail of the frame. An abort command flushes the FIFO and cuts off any frame in progress with a run of seven ones, and it answers with a one-cycle interrupt. Between frames the line carries continuous flags.

Commands are not applied at once. Each one waits a fixed number of clocks, and a mode input selects the short or the long delay. A busy output covers that wait. A command written while busy is high is dropped and recorded in a sticky error bit.

Top module: `hdlc_cmd_tx`

## Requirements
- R1: After reset, busy_o, cmd_lost_o and pool_ready_o are 0 and fifo_level_o is 0. The line carries back-to-back flags: the byte 0x7E, bits sent LSB first, giving 0,1,1,1,1,1,1,0.
- R2: The cmd_i codes are 0 = start HDLC frame, 1 = start transparent frame, 2 = message end and 3 = abort. An accepted write raises busy_o for exactly LAT_FAST clocks when slow_mode_i is 0, or LAT_SLOW clocks when it is 1. The command takes effect on the edge where busy_o falls.
- R3: A command written while busy_o is high has no effect and sets cmd_lost_o. cmd_lost_o stays set until rst_ni.
- R4: The FIFO holds DEPTH bytes and fifo_level_o shows its fill. A write while it is full is dropped.
- R5: An HDLC frame is sent after the current flag ends, as follows: one opening flag, the FIFO bytes LSB first, the check sequence, and then flags again.
- R6: The check sequence is the reflected CRC-16 with polynomial 0x8408, preset to 0xFFFF, run over the data bits. Its complement is sent low byte first, LSB first.
- R7: In data and check bits, a 0 is inserted after every five consecutive 1s. Flags and abort bits are never stuffed.
- R8: A transparent frame sends the FIFO bytes LSB first with no stuffing and no check sequence. It starts on a flag boundary, and flags resume once the FIFO is empty.
- R9: The abort command empties the FIFO. In the clock after it takes effect, pool_ready_o is 1 for one cycle and fifo_level_o is 0. The next seven line bits are 1, and flags follow them.
- R10: An abort issued during an HDLC frame cuts that frame off with the seven-ones pattern.
- R11: If the FIFO runs empty during an HDLC frame before a message-end command has taken effect, the frame ends with the seven-ones pattern and then flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Serial bit clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write one byte into the FIFO |
| wr_data_i | input | 8 | Byte to write |
| cmd_valid_i | input | 1 | Command write strobe |
| cmd_i | input | 2 | Command code (R2) |
| slow_mode_i | input | 1 | Selects the long command delay |
| busy_o | output | 1 | A command is pending |
| cmd_lost_o | output | 1 | Sticky: a command was dropped |
| pool_ready_o | output | 1 | One-cycle pulse after an abort |
| fifo_level_o | output | $clog2(DEPTH+1) | Bytes held in the FIFO |
| tx_bit_o | output | 1 | Serial line output |

## Verification
The bench builds the block with DEPTH = 8 and keeps the default delays of 5 and 10 clocks. With a FIFO of eight bytes, every frame length from one byte up to a full FIFO can be swept in both modes, and so can the dropped ninth write. The bench records the whole serial stream and decodes it on its own: it finds the flags, removes stuffed zeros and recomputes the CRC. All-ones payloads push zero insertion across byte and check-sequence boundaries. Each command's busy window is measured in both delay modes.

// File: rtl/hdlc_tx_pkg.sv
package hdlc_tx_pkg;
  typedef enum logic [1:0] {
    CMD_HDLC  = 2'd0,
    CMD_TRANS = 2'd1,
    CMD_END   = 2'd2,
    CMD_ABORT = 2'd3
  } tx_cmd_e;

  typedef enum logic [2:0] {
    U_FLAG, U_OPEN, U_DATA, U_FCS, U_ABORT
  } tx_unit_e;

  localparam logic [7:0] FLAG_BYTE = 8'h7E;

  // one LSB-first step of the reflected CCITT CRC
  function automatic logic [15:0] crc16_bit(logic [15:0] c, logic b);
    logic fb;
    fb = c[0] ^ b;
    return fb ? ((c >> 1) ^ 16'h8408) : (c >> 1);
  endfunction
endpackage

// File: rtl/hdlc_cmd_ctl.sv
module hdlc_cmd_ctl
  import hdlc_tx_pkg::*;
#(
  parameter int LAT_FAST = 5,
  parameter int LAT_SLOW = 10
) (
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    cmd_valid_i,
  input  logic [1:0] cmd_i,
  input  logic    slow_mode_i,
  output logic    busy_o,
  output logic    lost_o,
  output logic    exec_o,
  output tx_cmd_e exec_cmd_o
);
  localparam int CW = $clog2(LAT_SLOW + 1);

  logic          pend_q, lost_q;
  logic [CW-1:0] cnt_q;
  tx_cmd_e       cmd_q;

  assign exec_o     = pend_q && (cnt_q == CW'(1));
  assign exec_cmd_o = cmd_q;
  assign busy_o     = pend_q;
  assign lost_o     = lost_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      lost_q <= 1'b0;
      cnt_q  <= '0;
      cmd_q  <= CMD_HDLC;
    end else begin
      if (cmd_valid_i && pend_q) lost_q <= 1'b1;
      if (cmd_valid_i && !pend_q) begin
        pend_q <= 1'b1;
        cmd_q  <= tx_cmd_e'(cmd_i);
        cnt_q  <= slow_mode_i ? CW'(LAT_SLOW) : CW'(LAT_FAST);
      end else if (pend_q) begin
        cnt_q <= cnt_q - CW'(1);
        if (exec_o) pend_q <= 1'b0;
      end
    end
  end

  // R3
  lost_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && busy_o) |=> lost_o);
  // R3
  lost_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lost_o |=> lost_o);
  // R2
  delay_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> (cnt_q != '0 && cnt_q <= CW'(LAT_SLOW)));
endmodule

// File: rtl/hdlc_tx_fifo.sv
module hdlc_tx_fifo #(
  parameter int DEPTH = 32,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int LW = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [7:0]    data_i,
  input  logic          pop_i,
  input  logic          flush_i,
  output logic [7:0]    head_o,
  output logic          empty_o,
  output logic [LW-1:0] level_o
);
  logic [7:0]    mem_q [DEPTH];
  logic [AW-1:0] rd_q, wr_q;
  logic [LW-1:0] cnt_q;
  logic          do_wr, do_rd;

  assign empty_o = (cnt_q == '0);
  assign level_o = cnt_q;
  assign head_o  = mem_q[rd_q];
  assign do_wr   = wr_i && (cnt_q != LW'(DEPTH));
  assign do_rd   = pop_i && !empty_o;

  function automatic logic [AW-1:0] bump(logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= '0;
    end else if (flush_i) begin
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_wr) wr_q <= bump(wr_q);
      if (do_rd) rd_q <= bump(rd_q);
      cnt_q <= cnt_q + LW'(do_wr) - LW'(do_rd);
    end
  end

  always_ff @(posedge clk_i) begin
    if (do_wr && !flush_i) mem_q[wr_q] <= data_i;
  end

  // R4
  level_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    level_o <= LW'(DEPTH));
  // R4
  full_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (level_o == LW'(DEPTH) && wr_i && !pop_i && !flush_i) |=> $stable(level_o));
endmodule

// File: rtl/hdlc_tx_ser.sv
module hdlc_tx_ser
  import hdlc_tx_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_hdlc_i,
  input  logic       start_trans_i,
  input  logic       msg_end_i,
  input  logic       abort_i,
  input  logic       fifo_empty_i,
  input  logic [7:0] fifo_data_i,
  output logic       pop_o,
  output logic       tx_bit_o
);
  tx_unit_e    unit_q, unit_d;
  logic [15:0] sh_q, sh_d, crc_q, crc_nxt;
  logic [4:0]  left_q, left_d;
  logic [2:0]  ones_q;
  logic        trans_q, trans_d, pend_h_q, pend_t_q, end_q, tx_q;
  logic        stuff_now, last, stuffed_unit, crc_en;
  logic        take_h, take_t, load_fcs, init_crc;

  assign stuff_now    = (ones_q == 3'd5);
  assign last         = !stuff_now && (left_q == 5'd1);
  assign stuffed_unit = (unit_q == U_DATA && !trans_q) || unit_q == U_FCS;
  assign crc_en       = unit_q == U_DATA && !trans_q && !stuff_now;
  assign crc_nxt      = crc16_bit(crc_q, sh_q[0]);
  assign tx_bit_o     = tx_q;

  always_comb begin
    unit_d = unit_q; trans_d = trans_q;
    sh_d = sh_q >> 1; left_d = left_q - 5'd1;
    pop_o = 1'b0; take_h = 1'b0; take_t = 1'b0; load_fcs = 1'b0; init_crc = 1'b0;
    if (stuff_now) begin
      sh_d = sh_q; left_d = left_q;
    end else if (last) begin
      unit_d = U_FLAG; sh_d = {8'h00, FLAG_BYTE}; left_d = 5'd8;
      unique case (unit_q)
        U_FLAG: begin
          take_t = pend_t_q;
          if (pend_h_q) begin
            unit_d = U_OPEN; take_h = 1'b1; init_crc = 1'b1; trans_d = 1'b0;
          end else if (pend_t_q && !fifo_empty_i) begin
            unit_d = U_DATA; trans_d = 1'b1; pop_o = 1'b1;
          end
        end
        U_OPEN, U_DATA: begin
          if (!fifo_empty_i) begin
            unit_d = U_DATA; pop_o = 1'b1;
          end else if (unit_q == U_DATA && trans_q) begin
            unit_d = U_FLAG;
          end else if (unit_q == U_DATA && end_q) begin
            unit_d = U_FCS; sh_d = ~crc_nxt; left_d = 5'd16; load_fcs = 1'b1;
          end else begin
            unit_d = U_ABORT; sh_d = 16'h007F; left_d = 5'd7; // underrun
          end
        end
        default: ;
      endcase
      if (pop_o) sh_d = {8'h00, fifo_data_i};
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      unit_q <= U_FLAG; sh_q <= {8'h00, FLAG_BYTE}; left_q <= 5'd8;
      ones_q <= '0; crc_q <= '1; trans_q <= 1'b0; tx_q <= 1'b1;
      pend_h_q <= 1'b0; pend_t_q <= 1'b0; end_q <= 1'b0;
    end else if (abort_i) begin
      unit_q <= U_ABORT; sh_q <= 16'h007F; left_q <= 5'd7;
      ones_q <= '0; trans_q <= 1'b0;
      pend_h_q <= 1'b0; pend_t_q <= 1'b0; end_q <= 1'b0;
    end else begin
      tx_q    <= stuff_now ? 1'b0 : sh_q[0];
      unit_q  <= unit_d; sh_q <= sh_d; left_q <= left_d; trans_q <= trans_d;
      ones_q  <= (!stuff_now && stuffed_unit && sh_q[0]) ? ones_q + 3'd1 : 3'd0;
      if (init_crc)    crc_q <= '1;
      else if (crc_en) crc_q <= crc_nxt;
      pend_h_q <= start_hdlc_i  | (pend_h_q & ~take_h);
      pend_t_q <= start_trans_i | (pend_t_q & ~take_t);
      end_q    <= msg_end_i | (end_q & ~load_fcs & ~(last && unit_d == U_ABORT));
    end
  end

  // R7
  run_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ones_q <= 3'd5);
  // R9
  abort_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_i |=> (unit_q == U_ABORT && left_q == 5'd7));
  // R11
  underrun_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (last && unit_q == U_DATA && !trans_q && fifo_empty_i && !end_q && !abort_i)
      |=> unit_q == U_ABORT);
endmodule

// File: rtl/hdlc_cmd_tx.sv
module hdlc_cmd_tx
  import hdlc_tx_pkg::*;
#(
  parameter int DEPTH    = 32,
  parameter int LAT_FAST = 5,
  parameter int LAT_SLOW = 10
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         wr_en_i,
  input  logic [7:0]                   wr_data_i,
  input  logic                         cmd_valid_i,
  input  logic [1:0]                   cmd_i,
  input  logic                         slow_mode_i,
  output logic                         busy_o,
  output logic                         cmd_lost_o,
  output logic                         pool_ready_o,
  output logic [$clog2(DEPTH+1)-1:0]   fifo_level_o,
  output logic                         tx_bit_o
);
  logic       exec, pop, empty, pool_q, abort;
  tx_cmd_e    exec_cmd;
  logic [7:0] head;

  assign abort        = exec && exec_cmd == CMD_ABORT;
  assign pool_ready_o = pool_q;

  hdlc_cmd_ctl #(.LAT_FAST(LAT_FAST), .LAT_SLOW(LAT_SLOW)) u_ctl (
    .clk_i, .rst_ni, .cmd_valid_i, .cmd_i, .slow_mode_i,
    .busy_o, .lost_o(cmd_lost_o), .exec_o(exec), .exec_cmd_o(exec_cmd)
  );

  hdlc_tx_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk_i, .rst_ni, .wr_i(wr_en_i), .data_i(wr_data_i), .pop_i(pop),
    .flush_i(abort), .head_o(head), .empty_o(empty), .level_o(fifo_level_o)
  );

  hdlc_tx_ser u_ser (
    .clk_i, .rst_ni,
    .start_hdlc_i (exec && exec_cmd == CMD_HDLC),
    .start_trans_i(exec && exec_cmd == CMD_TRANS),
    .msg_end_i    (exec && exec_cmd == CMD_END),
    .abort_i      (abort),
    .fifo_empty_i (empty), .fifo_data_i(head), .pop_o(pop), .tx_bit_o
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pool_q <= 1'b0;
    else         pool_q <= abort;
  end

  // R9
  pool_flush_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pool_ready_o |-> fifo_level_o == '0);
  // R9
  pool_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pool_ready_o |=> !pool_ready_o);
endmodule

// File: tb/sim_hdlc_cmd_tx.sv
module sim_hdlc_cmd_tx;
  timeunit 1ns; timeprecision 1ps;
  localparam int DEPTH = 8;
  localparam int LW = $clog2(DEPTH + 1);

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 0, cmd_valid = 0, slow = 0;
  logic [7:0] wr_data = '0;
  logic [1:0] cmd = '0;
  logic busy, lost, pool, tx;
  logic [LW-1:0] level;

  always #2 clk = ~clk;

  hdlc_cmd_tx #(.DEPTH(DEPTH)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .cmd_valid_i(cmd_valid), .cmd_i(cmd), .slow_mode_i(slow),
    .busy_o(busy), .cmd_lost_o(lost), .pool_ready_o(pool),
    .fifo_level_o(level), .tx_bit_o(tx)
  );

  int checks = 0, errors = 0, cyc = 0, pool_seen = 0, cidx = 0;
  logic cap [0:32767];
  logic [7:0] expb [0:15];
  logic [7:0] dec [0:15];
  int dec_n;

  always @(negedge clk) begin
    if (cidx < 32768) begin cap[cidx] = tx; cidx++; end
    cyc++;
    if (pool) pool_seen++;
    if (cyc == 150000) begin
      errors++; checks++;
      $display("FAIL watchdog all: actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic push(logic [7:0] b);
    @(negedge clk); wr_en = 1; wr_data = b;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic issue(logic [1:0] c, logic s, output int lat);
    @(negedge clk); cmd_valid = 1; cmd = c; slow = s;
    @(negedge clk); cmd_valid = 0;
    lat = 0;
    while (busy) begin lat++; @(negedge clk); end
  endtask

  function automatic bit is_flag(int i);
    return cap[i] == 0 && cap[i+1] && cap[i+2] && cap[i+3] && cap[i+4]
        && cap[i+5] && cap[i+6] && cap[i+7] == 0;
  endfunction

  task automatic skip_flags(inout int i);
    while (!is_flag(i) && i < cidx) i++;
    while (is_flag(i)) i += 8;
  endtask

  // status: 0 closed by flag, 1 abort seen, 2 ran off capture
  task automatic dec_hdlc(int from, output int status);
    int i, ones, nb;
    i = from; ones = 0; nb = 0; status = 2;
    skip_flags(i);
    for (int k = 0; k < 1000 && i < cidx - 8; k++) begin
      if (is_flag(i)) begin status = 0; break; end
      if (ones == 5) begin
        if (cap[i]) begin status = 1; break; end
        ones = 0;
      end else begin
        dec[nb/8][nb%8] = cap[i];
        nb++;
        ones = cap[i] ? ones + 1 : 0;
      end
      i++;
    end
    dec_n = (nb % 8 == 0) ? nb / 8 : -1;
  endtask

  function automatic logic [15:0] fcs_of(int n);
    logic [15:0] c = 16'hFFFF;
    for (int j = 0; j < n; j++)
      for (int b = 0; b < 8; b++)
        c = (c[0] ^ expb[j][b]) ? ((c >> 1) ^ 16'h8408) : (c >> 1);
    return ~c;
  endfunction

  task automatic dec_trans(int from, int n, output int mism, output int tail);
    int i = from;
    skip_flags(i);
    mism = 0;
    for (int j = 0; j < n; j++)
      for (int b = 0; b < 8; b++) begin
        if (cap[i] !== expb[j][b]) mism++;
        i++;
      end
    tail = is_flag(i);
  endtask

  task automatic abort_tail(string req);
    int ones = 0, fl;
    chk(req, "pool_ready after abort", pool, 1);
    chk(req, "fifo level after abort", level, 0);
    for (int k = 0; k < 7; k++) begin @(negedge clk); ones += tx; end
    chk(req, "abort ones", ones, 7);
    fl = 0;
    for (int k = 0; k < 8; k++) begin @(negedge clk); fl = {fl[30:0], tx}; end
    chk(req, "flag after abort", fl, 8'b0111_1110);
    chk(req, "pool pulse width", pool_seen, 1);
  endtask

  initial begin
    int lat, st, stat, mism, tail, sfl;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (24) @(negedge clk);
    // R1
    chk("R1", "busy", busy, 0); chk("R1", "lost", lost, 0);
    chk("R1", "pool", pool, 0); chk("R1", "level", level, 0);
    sfl = 0; while (!is_flag(sfl)) sfl++;
    chk("R1", "idle flags", is_flag(sfl + 8) && is_flag(sfl + 16), 1);

    // R5 R6 R7 R2: HDLC sweep over lengths and two patterns
    for (int p = 0; p < 2; p++)
      for (int n = 1; n <= DEPTH; n++) begin
        for (int j = 0; j < n; j++) begin
          expb[j] = p ? 8'hFF : 8'((n * 29 + j * 53 + 1) & 8'hFF);
          push(expb[j]);
        end
        st = cidx;
        issue(2'd0, 1'(n % 2), lat);
        chk("R2", "start delay", lat, (n % 2) ? 10 : 5);
        issue(2'd2, 1'b0, lat);
        chk("R2", "end delay", lat, 5);
        while (level != 0) @(negedge clk);
        repeat (60) @(negedge clk);
        dec_hdlc(st, stat);
        chk("R7", "frame closed without six-ones run", stat, 0);
        chk("R5", "frame byte count", dec_n, n + 2);
        mism = 0;
        for (int j = 0; j < n; j++) if (dec[j] != expb[j]) mism++;
        chk("R5", "payload mismatches", mism, 0);
        chk("R6", "fcs", {dec[n+1], dec[n]}, fcs_of(n));
      end

    // R8 R4: transparent sweep, full FIFO drops extra write
    for (int n = 1; n <= DEPTH; n++) begin
      for (int j = 0; j < n; j++) begin
        expb[j] = (n == DEPTH) ? 8'hFF : 8'((j * 71 + n * 13 + 17) & 8'hFF);
        push(expb[j]);
      end
      if (n == DEPTH) begin
        push(8'h00);
        chk("R4", "level after overfill", level, DEPTH);
      end else chk("R4", "level", level, n);
      st = cidx;
      issue(2'd1, 1'b0, lat);
      while (level != 0) @(negedge clk);
      repeat (30) @(negedge clk);
      dec_trans(st, n, mism, tail);
      chk("R8", "raw bit mismatches", mism, 0);
      chk("R8", "flag after data", tail, 1);
    end

    // R11 underrun
    for (int j = 0; j < 3; j++) push(8'h3C);
    st = cidx;
    issue(2'd0, 1'b0, lat);
    while (level != 0) @(negedge clk);
    repeat (40) @(negedge clk);
    dec_hdlc(st, stat);
    chk("R11", "underrun ends in abort", stat, 1);

    // R9 abort from idle
    pool_seen = 0;
    issue(2'd3, 1'b1, lat);
    chk("R2", "abort delay slow", lat, 10);
    abort_tail("R9");

    // R10 abort mid-frame
    for (int j = 0; j < DEPTH; j++) push(8'h00);
    st = cidx;
    issue(2'd0, 1'b0, lat);
    while (level > 5) @(negedge clk);
    pool_seen = 0;
    issue(2'd3, 1'b0, lat);
    abort_tail("R10");
    dec_hdlc(st, stat);
    chk("R10", "frame cut by abort", stat, 1);

    // R3 write while busy is dropped
    for (int j = 0; j < 4; j++) begin expb[j] = 8'(j * 45 + 9); push(expb[j]); end
    pool_seen = 0;
    st = cidx;
    @(negedge clk); cmd_valid = 1; cmd = 2'd1; slow = 0;
    @(negedge clk); cmd = 2'd3;
    @(negedge clk); cmd_valid = 0;
    chk("R3", "lost flag set", lost, 1);
    while (level != 0) @(negedge clk);
    repeat (30) @(negedge clk);
    chk("R3", "dropped abort gave no pool_ready", pool_seen, 0);
    dec_trans(st, 4, mism, tail);
    chk("R3", "frame still sent", mism, 0);
    chk("R3", "lost flag sticky", lost, 1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule